// File: doc/BRIEF.md
# Narrow-Bus 32-bit Register Access Bridge

This block lets an external host with an 8-bit or a 16-bit data bus reach 32-bit on-chip registers one lane at a time. The host picks a register with a 6-bit select field and sets the bus width and an order bit. It then issues read or write strobes. A 2-bit lane pointer decides which 8-bit or 16-bit slice of the chosen register is reached. The order bit reverses the mapping from pointer codes to lanes.

The host drives a control pin, `h_ctl`. While this pin is high, a host write loads the lane pointer from the low data bits and touches no register. Reads still return lane data in that state. While the pin is low, host writes go to the lane of the selected register. The pointer steps forward by itself after every read or write of the data window register. The step sequence depends on the bus width.

Two registers are implemented. The data window register is host-writable and visible on chip through `win_o`. The shared status register stores its low 8 bits, and its upper bits always read as zero. The on-chip side writes it through a separate 32-bit port and reads it on `st_o`.

Top module: `narrow_reg_bridge`

## Requirements
- R1: With `h_wide`=0 and `h_order`=0, pointer codes 0, 1, 2 and 3 reach register bits 31:24, 23:16, 15:8 and 7:0. The lane is returned on `h_rdata[7:0]` with `h_rdata[15:8]`=0.
- R2: With `h_wide`=0 and `h_order`=1, codes 0, 1, 2 and 3 reach bits 7:0, 15:8, 23:16 and 31:24.
- R3: With `h_wide`=1, code 0 reaches bits 31:16 and code 2 reaches bits 15:0 when `h_order`=0. With `h_order`=1 the two are swapped. Odd codes are prohibited: a read returns 0 and a data write changes nothing.
- R4: On an 8-bit bus, each read or data write of the data window (select 5) steps the pointer 0→1→2→3→0 at the next clock edge.
- R5: On a 16-bit bus, each such access sets the pointer to {~p[1],0}, so it alternates 0→2→0.
- R6: An access to any select other than the data window leaves the pointer unchanged. A read of an unimplemented select (anything but 2 or 5) returns 0, and a write to one has no effect.
- R7: A host write with `h_ctl`=1 loads the pointer from `h_wdata[1:0]` and does not step it. With `h_wide`=1, an odd value is ignored and the pointer keeps its previous value.
- R8: The status register (select 2) reads with bits 31:8 always 0. A host write reaches it only with `h_ctl`=0. A write with `h_ctl`=1 leaves it unchanged, and a read with `h_ctl`=1 still returns its lane.
- R9: A narrow write changes only the addressed lane. The other lanes keep their values.
- R10: When `cpu_st_we` and a host status write fall in the same cycle, the on-chip value is stored.
- R11: After a synchronous active-low reset, the pointer, the status register and the data window register are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_wide | input | 1 | Host bus width: 0 = 8-bit, 1 = 16-bit |
| h_order | input | 1 | Lane order select |
| h_ctl | input | 1 | 1: writes load the pointer; 0: writes go to registers |
| h_sel | input | 6 | Register select |
| h_rd | input | 1 | Host read strobe, one cycle per access |
| h_wr | input | 1 | Host write strobe, one cycle per access |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Lane read data, combinational from the current pointer |
| h_pos | output | 2 | Current lane pointer |
| cpu_st_we | input | 1 | On-chip status write enable |
| cpu_st_wdata | input | 32 | On-chip status write data |
| st_o | output | 32 | Status register value |
| win_o | output | 32 | Data window register value |

## Verification
The hardest case is a 16-bit access made while the pointer holds an odd code. A 16-bit pointer load refuses odd values, so this state cannot be reached directly. The bench loads the odd code over an 8-bit bus and then switches the width to 16 bits. It then reads and writes the data window in that state. The expected results are a zero read, a data write that is dropped, and the pointer stepping to the even code. A same-cycle collision between an on-chip write and a host write to the status register is set up the same way. The pointer is first steered to the status low lane, so that the host write would otherwise land.

// File: rtl/bridge_pkg.sv
// Package: shared widths and the bus-width encoding for the narrow-bus bridge.
// Assumes a register is exactly four 8-bit lanes wide.
package bridge_pkg;
    localparam int unsigned LANE_W = 8;
    localparam int unsigned REG_W  = 4 * LANE_W;
    localparam int unsigned POS_W  = 2;

    typedef enum logic {
        BUS_NARROW = 1'b0,
        BUS_WIDE   = 1'b1
    } bus_width_e;

    typedef logic [POS_W-1:0] lane_pos_t;
endpackage

// File: rtl/brg_lane_map.sv
// Lane map: turns the lane pointer, order bit and bus width into a bit mask
// and a shift amount within a REG_W-bit register.
// Assumes REG_W = 4 * LANE_W and a 2-bit pointer. Odd codes on the wide bus
// are flagged illegal and produce an all-zero mask.
module brg_lane_map #(
    parameter int unsigned REG_W  = 32,
    parameter int unsigned LANE_W = 8,
    localparam int unsigned SH_W  = $clog2(REG_W),
    localparam int unsigned NLANE = REG_W / LANE_W
) (
    input  logic [1:0]       pos,
    input  logic             order,
    input  logic             wide,
    output logic [REG_W-1:0] mask,
    output logic [SH_W-1:0]  lsb,
    output logic             legal
);
    logic [1:0] lane_idx;
    logic       half_idx;

    // Pick the lane index (0 = least significant) and build the mask from it.
    always_comb begin
        lane_idx = order ? pos : 2'(NLANE - 1 - int'(pos));
        half_idx = order ? pos[1] : ~pos[1];
        if (!wide) begin
            legal = 1'b1;
            lsb   = SH_W'(int'(lane_idx) * LANE_W);
            mask  = REG_W'({LANE_W{1'b1}}) << lsb;
        end else begin
            legal = ~pos[0];
            lsb   = SH_W'(int'(half_idx) * 2 * LANE_W);
            mask  = legal ? (REG_W'({(2*LANE_W){1'b1}}) << lsb) : '0;
        end
    end
endmodule

// File: rtl/brg_pos_ptr.sv
// Lane pointer: holds the 2-bit lane position. A host control write loads it,
// and every data-window access steps it.
// Assumes load and adv are never high together (the top gives load priority).
module brg_pos_ptr (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wide,
    input  logic       load,
    input  logic [1:0] load_val,
    input  logic       adv,
    output logic [1:0] pos
);
    // Pointer update: a load (odd values refused on the wide bus), else a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= 2'b00;
        end else if (load) begin
            if (!(wide && load_val[0])) begin
                pos <= load_val;
            end
        end else if (adv) begin
            pos <= wide ? {~pos[1], 1'b0} : pos + 2'd1;
        end
    end

    a_r4_step_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && !wide) |=> (pos == 2'($past(pos) + 2'd1)));

    a_r5_step_wide: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && wide) |=> (pos[0] == 1'b0 && pos[1] != $past(pos[1])));

    a_r7_odd_load_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (load && wide && load_val[0]) |=> $stable(pos));

    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> $stable(pos));
endmodule

// File: rtl/brg_lane_reg.sv
// Lane-writable register: REG_W bits seen from outside, of which only the low
// KEEP_W bits are stored and the rest read as zero. The host writes through a
// lane mask. The on-chip side writes whole words and wins a same-cycle clash.
module brg_lane_reg #(
    parameter int unsigned REG_W  = 32,
    parameter int unsigned KEEP_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [REG_W-1:0] host_mask,
    input  logic [REG_W-1:0] host_val,
    input  logic             cpu_we,
    input  logic [REG_W-1:0] cpu_val,
    output logic [REG_W-1:0] q
);
    logic [KEEP_W-1:0] store;

    // Storage update: the on-chip write first, else a masked host lane merge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store <= '0;
        end else if (cpu_we) begin
            store <= cpu_val[KEEP_W-1:0];
        end else if (host_we) begin
            store <= (store & ~host_mask[KEEP_W-1:0])
                   | (host_val[KEEP_W-1:0] & host_mask[KEEP_W-1:0]);
        end
    end

    // Zero-pad the unstored upper bits when the register is narrower.
    generate
        if (KEEP_W < REG_W) begin : g_pad
            assign q = {{(REG_W-KEEP_W){1'b0}}, store};
        end else begin : g_full
            assign q = store;
        end
    endgenerate

    a_r9_other_lanes_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && !cpu_we) |=> (((q ^ $past(q)) & ~$past(host_mask)) == '0));

    a_r10_onchip_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_we |=> (q[KEEP_W-1:0] == $past(cpu_val[KEEP_W-1:0])));
endmodule

// File: rtl/narrow_reg_bridge.sv
// Narrow-bus register bridge top: decodes host strobes, steers 8/16-bit lanes
// into the data window and status registers, and runs the lane pointer.
// Assumes single-cycle strobes. If h_rd and h_wr are both high, the access is
// treated as a write.
module narrow_reg_bridge #(
    parameter int unsigned SEL_W    = 6,
    parameter int unsigned STAT_W   = 8,
    parameter int unsigned WIN_IDX  = 5,
    parameter int unsigned STAT_IDX = 2,
    localparam int unsigned REG_W   = bridge_pkg::REG_W,
    localparam int unsigned LANE_W  = bridge_pkg::LANE_W,
    localparam int unsigned BUS_W   = 2 * LANE_W,
    localparam int unsigned SH_W    = $clog2(REG_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             h_wide,
    input  logic             h_order,
    input  logic             h_ctl,
    input  logic [SEL_W-1:0] h_sel,
    input  logic             h_rd,
    input  logic             h_wr,
    input  logic [BUS_W-1:0] h_wdata,
    output logic [BUS_W-1:0] h_rdata,
    output logic [1:0]       h_pos,
    input  logic             cpu_st_we,
    input  logic [REG_W-1:0] cpu_st_wdata,
    output logic [REG_W-1:0] st_o,
    output logic [REG_W-1:0] win_o
);
    import bridge_pkg::*;

    logic             acc, ptr_load, hit_win, hit_st, adv, data_we, legal;
    logic [REG_W-1:0] mask, wval, sel_q;
    logic [SH_W-1:0]  lsb;
    logic [BUS_W-1:0] wdata_ext;

    // Access decode: pointer load, window step and data-write qualification.
    always_comb begin
        acc      = h_rd | h_wr;
        ptr_load = h_wr & h_ctl;
        hit_win  = (h_sel == SEL_W'(WIN_IDX));
        hit_st   = (h_sel == SEL_W'(STAT_IDX));
        adv      = acc & hit_win & ~ptr_load;
        data_we  = h_wr & ~h_ctl & legal;
    end

    // Align host write data to the selected lane.
    always_comb begin
        wdata_ext = (h_wide == BUS_WIDE) ? h_wdata : BUS_W'(h_wdata[LANE_W-1:0]);
        wval      = REG_W'(wdata_ext) << lsb;
    end

    // Read steering: pick the register, then extract the addressed lane.
    always_comb begin
        if (hit_win)     sel_q = win_o;
        else if (hit_st) sel_q = st_o;
        else             sel_q = '0;
        h_rdata = BUS_W'((sel_q & mask) >> lsb);
    end

    brg_lane_map #(.REG_W(REG_W), .LANE_W(LANE_W)) u_map (
        .pos   (h_pos),
        .order (h_order),
        .wide  (h_wide),
        .mask  (mask),
        .lsb   (lsb),
        .legal (legal)
    );

    brg_pos_ptr u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wide     (h_wide),
        .load     (ptr_load),
        .load_val (h_wdata[1:0]),
        .adv      (adv),
        .pos      (h_pos)
    );

    brg_lane_reg #(.REG_W(REG_W), .KEEP_W(REG_W)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_we   (data_we & hit_win),
        .host_mask (mask),
        .host_val  (wval),
        .cpu_we    (1'b0),
        .cpu_val   ({REG_W{1'b0}}),
        .q         (win_o)
    );

    brg_lane_reg #(.REG_W(REG_W), .KEEP_W(STAT_W)) u_st (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_we   (data_we & hit_st),
        .host_mask (mask),
        .host_val  (wval),
        .cpu_we    (cpu_st_we),
        .cpu_val   (cpu_st_wdata),
        .q         (st_o)
    );

    a_r6_other_select_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !hit_win && !ptr_load) |=> $stable(h_pos));

    a_r7_ctl_write_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && h_ctl && !cpu_st_we) |=> ($stable(st_o) && $stable(win_o)));

    a_r3_odd_wide_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wide && h_pos[0]) |-> (h_rdata == '0));

    a_r1_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !h_wide |-> (h_rdata[BUS_W-1:LANE_W] == '0));

    a_r8_status_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_st_we |=> (st_o[REG_W-1:STAT_W] == '0));
endmodule

// File: tb/narrow_reg_bridge_tb.sv
`timescale 1ns/1ps
module narrow_reg_bridge_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_wide = 1'b0, h_order = 1'b0, h_ctl = 1'b0;
    logic [5:0]  h_sel = '0;
    logic        h_rd = 1'b0, h_wr = 1'b0;
    logic [15:0] h_wdata = '0;
    logic [15:0] h_rdata;
    logic [1:0]  h_pos;
    logic        cpu_st_we = 1'b0;
    logic [31:0] cpu_st_wdata = '0;
    logic [31:0] st_o, win_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    narrow_reg_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .h_wide(h_wide), .h_order(h_order),
        .h_ctl(h_ctl), .h_sel(h_sel), .h_rd(h_rd), .h_wr(h_wr),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .h_pos(h_pos),
        .cpu_st_we(cpu_st_we), .cpu_st_wdata(cpu_st_wdata),
        .st_o(st_o), .win_o(win_o)
    );

    typedef struct packed {
        logic        wr;
        logic        ctl;
        logic        wide;
        logic        ord;
        logic [5:0]  sel;
        logic [15:0] wdata;
        logic [15:0] exp_rd;
        logic [1:0]  exp_pos;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 37;
    localparam vec_t TBL [NV] = '{
        '{1'b1,1'b1,1'b0,1'b0,6'd5,16'h0000,16'h0000,2'd0,4'd7},  // R7 load 0
        '{1'b1,1'b0,1'b0,1'b0,6'd5,16'h0011,16'h0000,2'd1,4'd4},  // R4 R1 write 31:24
        '{1'b1,1'b0,1'b0,1'b0,6'd5,16'h0022,16'h0000,2'd2,4'd4},
        '{1'b1,1'b0,1'b0,1'b0,6'd5,16'h0033,16'h0000,2'd3,4'd4},
        '{1'b1,1'b0,1'b0,1'b0,6'd5,16'h0044,16'h0000,2'd0,4'd4},  // wraps 3->0
        '{1'b0,1'b0,1'b0,1'b0,6'd5,16'h0000,16'h0011,2'd1,4'd1},  // R1 read
        '{1'b0,1'b0,1'b0,1'b1,6'd5,16'h0000,16'h0033,2'd2,4'd2},  // R2 code1 -> 15:8
        '{1'b0,1'b0,1'b0,1'b1,6'd5,16'h0000,16'h0022,2'd3,4'd2},
        '{1'b0,1'b0,1'b0,1'b1,6'd5,16'h0000,16'h0011,2'd0,4'd2},
        '{1'b0,1'b0,1'b0,1'b1,6'd5,16'h0000,16'h0044,2'd1,4'd2},
        '{1'b1,1'b1,1'b1,1'b0,6'd5,16'h0000,16'h0000,2'd0,4'd7},  // R7 wide load 0
        '{1'b0,1'b0,1'b1,1'b0,6'd5,16'h0000,16'h1122,2'd2,4'd3},  // R3 R5
        '{1'b0,1'b0,1'b1,1'b0,6'd5,16'h0000,16'h3344,2'd0,4'd5},
        '{1'b0,1'b0,1'b1,1'b1,6'd5,16'h0000,16'h3344,2'd2,4'd3},
        '{1'b1,1'b0,1'b1,1'b1,6'd5,16'hAABB,16'h0000,2'd0,4'd9},  // R9 upper half only
        '{1'b0,1'b0,1'b1,1'b0,6'd5,16'h0000,16'hAABB,2'd2,4'd3},
        '{1'b1,1'b1,1'b1,1'b0,6'd5,16'h0001,16'h0000,2'd2,4'd7},  // R7 odd refused
        '{1'b1,1'b1,1'b0,1'b0,6'd5,16'h0001,16'h0000,2'd1,4'd7},
        '{1'b0,1'b0,1'b0,1'b0,6'd2,16'h0000,16'h0000,2'd1,4'd6},  // R6 status read
        '{1'b1,1'b0,1'b0,1'b0,6'd2,16'h005A,16'h0000,2'd1,4'd8},  // R8 upper lane
        '{1'b1,1'b1,1'b0,1'b0,6'd5,16'h0003,16'h0000,2'd3,4'd7},
        '{1'b1,1'b0,1'b0,1'b0,6'd2,16'h005A,16'h0000,2'd3,4'd8},
        '{1'b0,1'b1,1'b0,1'b0,6'd2,16'h0000,16'h005A,2'd3,4'd8},  // R8 read ctl=1
        '{1'b0,1'b1,1'b0,1'b0,6'd5,16'h0000,16'h0044,2'd0,4'd4},
        '{1'b0,1'b0,1'b0,1'b0,6'd2,16'h0000,16'h0000,2'd0,4'd8},
        '{1'b0,1'b0,1'b0,1'b0,6'd7,16'h0000,16'h0000,2'd0,4'd6},  // R6 unused select
        '{1'b1,1'b0,1'b0,1'b0,6'd7,16'h0099,16'h0000,2'd0,4'd6},
        '{1'b1,1'b1,1'b0,1'b0,6'd7,16'h0002,16'h0000,2'd2,4'd7},
        '{1'b0,1'b0,1'b0,1'b0,6'd5,16'h0000,16'h0033,2'd3,4'd1},
        '{1'b1,1'b1,1'b0,1'b0,6'd2,16'h0000,16'h0000,2'd0,4'd8},  // R8 ctl write no data
        '{1'b0,1'b0,1'b0,1'b1,6'd2,16'h0000,16'h005A,2'd0,4'd8},
        '{1'b1,1'b1,1'b0,1'b0,6'd5,16'h0001,16'h0000,2'd1,4'd7},
        '{1'b0,1'b0,1'b1,1'b0,6'd5,16'h0000,16'h0000,2'd2,4'd3},  // R3 odd wide read
        '{1'b1,1'b1,1'b0,1'b0,6'd5,16'h0003,16'h0000,2'd3,4'd7},
        '{1'b1,1'b0,1'b1,1'b0,6'd5,16'hFFFF,16'h0000,2'd0,4'd3},  // R3 odd write drop
        '{1'b0,1'b0,1'b1,1'b0,6'd5,16'h0000,16'hAABB,2'd2,4'd3},
        '{1'b0,1'b0,1'b1,1'b0,6'd5,16'h0000,16'h3344,2'd0,4'd9}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 pos", 32'(h_pos), 32'h0);
        check("R11 status", st_o, 32'h0);
        check("R11 window", win_o, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            h_wide = TBL[i].wide; h_order = TBL[i].ord; h_ctl = TBL[i].ctl;
            h_sel = TBL[i].sel; h_wdata = TBL[i].wdata;
            h_wr = TBL[i].wr; h_rd = ~TBL[i].wr;
            #1;
            if (!TBL[i].wr)
                check($sformatf("vec %0d R%0d rdata", i, TBL[i].req),
                      32'(h_rdata), 32'(TBL[i].exp_rd));
            @(negedge clk);
            h_rd = 1'b0; h_wr = 1'b0;
            check($sformatf("vec %0d R%0d pos", i, TBL[i].req),
                  32'(h_pos), 32'(TBL[i].exp_pos));
        end

        // R9 the whole window after lane writes
        check("R9 window word", win_o, 32'hAABB3344);
        check("R8 status word", st_o, 32'h0000005A);

        // R10 on-chip write wins over a host write to status lane 7:0
        @(negedge clk);
        h_wide = 1'b0; h_order = 1'b1; h_ctl = 1'b0; h_sel = 6'd2;
        h_wdata = 16'h0011; h_wr = 1'b1;
        cpu_st_we = 1'b1; cpu_st_wdata = 32'hFFFF_FF77;
        @(negedge clk);
        h_wr = 1'b0; cpu_st_we = 1'b0;
        check("R10 on-chip wins", st_o, 32'h00000077);

        // R8 host write alone lands in the low status lane
        @(negedge clk);
        h_wr = 1'b1;
        @(negedge clk);
        h_wr = 1'b0;
        check("R8 host status write", st_o, 32'h00000011);

        // R11 reset mid-run clears everything
        @(negedge clk);
        h_ctl = 1'b1; h_wdata = 16'h0002; h_wr = 1'b1;
        @(negedge clk);
        h_wr = 1'b0; h_ctl = 1'b0;
        check("R7 pos before reset", 32'(h_pos), 32'h2);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R11 pos after reset", 32'(h_pos), 32'h0);
        check("R11 status after reset", st_o, 32'h0);
        check("R11 window after reset", win_o, 32'h0);

        finish_run();
    end
endmodule